// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block decides, slot by slot, which internal serial channel owns each 8-bit time slot of a TDM frame. Routing is not held as a per-slot map. It is held as an ordered list of runs, and each run names a number of consecutive slots and a destination code. At every frame start the walker begins again at the first run. It advances one slot per slot strobe and moves to the next run when the current run is used up.

The receive and transmit paths each have their own table and their own slot and frame strobes. On receive, the completed slot byte is steered to one of five channel write enables, or it is dropped when the slot is unused. On transmit, the block picks the channel lane that supplies the byte for the slot and pulses a pop to that channel. It sends all ones when the slot is unused or the chosen channel has nothing to give.

A single write port loads the entries into a shadow copy. The walker only adopts that copy at the next frame start, so a frame in progress always finishes on one consistent table.

Top module: `tsr_slot_router`

## Requirements
- R1: Entries apply in index order to consecutive slots starting at slot 0 of the frame. An entry's count field holds the number of slots minus one, so it covers 1 to 64 slots.
- R2: A slot strobe with the frame flag set is slot 0. It restarts the walk at entry 0 wherever the previous frame stopped.
- R3: After an entry with its last flag set, or after entry 63, every further slot is unused until the next frame start.
- R4: One cycle after each receive slot strobe, the receive valid output pulses for one cycle with the slot byte and the channel code. Write-enable bit c-1 is set for codes 1 to 5, and all write enables stay low for code 0 (discard).
- R5: On transmit, a slot with code c in 1 to 5 whose channel reports data available outputs byte lane c-1 of the data input (bits 8(c-1)+7 down to 8(c-1)) one cycle after the strobe. Pop bit c-1 pulses at the same time.
- R6: On transmit, an unused slot or a slot whose channel has no data outputs 0xFF and raises no pop.
- R7: Table writes go to a shadow copy. A frame already running keeps the old routing, and the new routing takes effect from the next frame start.
- R8: The direction bit of the write port (0 receive, 1 transmit) selects one of two independent tables. Writing one table leaves the routing of the other unchanged.
- R9: Destination codes 6 and 7 are stored as code 0 (unused).
- R10: After reset the outputs are low. Until the first frame start, every slot is unused: receive code 0 with no write enable, and transmit 0xFF with no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_tx_i | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_idx_i | input | 6 | Entry index |
| cfg_cnt_i | input | 6 | Slots in run minus one |
| cfg_dst_i | input | 3 | Destination code |
| cfg_last_i | input | 1 | Entry ends the table |
| rx_slot_i | input | 1 | Receive slot completed |
| rx_frame_i | input | 1 | Receive slot is slot 0 |
| rx_byte_i | input | 8 | Received slot byte |
| rx_valid_o | output | 1 | Receive slot result valid |
| rx_ch_o | output | 3 | Receive channel code |
| rx_byte_o | output | 8 | Receive slot byte |
| rx_we_o | output | 5 | Per-channel receive write enable |
| tx_slot_i | input | 1 | Transmit slot request |
| tx_frame_i | input | 1 | Transmit slot is slot 0 |
| tx_avail_i | input | 5 | Per-channel transmit data available |
| tx_data_i | input | 40 | Per-channel transmit byte lanes |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ch_o | output | 3 | Transmit channel code |
| tx_byte_o | output | 8 | Transmit slot byte |
| tx_pop_o | output | 5 | Per-channel transmit pop |

## Verification
The assertions assume the following about the inputs: a frame flag is only meaningful together with its slot strobe, and a channel's data-available bit is steady in the cycle the slot strobe samples it. The bench drives every strobe for exactly one cycle, with idle cycles between slots. It changes tables only between slots and never while a frame strobe is being sampled. It writes destination codes from the full 3-bit range, so the out-of-range codes 6 and 7 are exercised at the write port and never reach the outputs.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int unsigned TSR_CNT_W  = 6;
  localparam int unsigned TSR_CODE_W = 3;

  typedef struct packed {
    logic                  last;
    logic [TSR_CODE_W-1:0] dst;
    logic [TSR_CNT_W-1:0]  cnt;
  } tsr_route_t;
endpackage

// File: rtl/tsr_route_walker.sv
module tsr_route_walker
  import tsr_pkg::*;
#(
  parameter int unsigned MAX_ENT = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [$clog2(MAX_ENT)-1:0] wr_idx_i,
  input  tsr_route_t            wr_ent_i,
  input  logic                  slot_i,
  input  logic                  frame_i,
  output logic [TSR_CODE_W-1:0] dst_o
);
  localparam int unsigned IDX_W = $clog2(MAX_ENT);

  tsr_route_t shadow_q [MAX_ENT];
  tsr_route_t active_q [MAX_ENT];

  logic [IDX_W-1:0]     idx_q, idx_n, cur_idx;
  logic [TSR_CNT_W-1:0] used_q, used_n, cur_used;
  logic                 done_q, done_n, cur_done;
  tsr_route_t           cur_ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_ENT; i++) shadow_q[i] <= '0;
    end else if (wr_en_i) begin
      shadow_q[wr_idx_i] <= wr_ent_i;
    end
  end

  // shadow becomes live only at slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_ENT; i++) active_q[i] <= '0;
    end else if (slot_i && frame_i) begin
      for (int i = 0; i < MAX_ENT; i++) active_q[i] <= shadow_q[i];
    end
  end

  always_comb begin
    cur_idx  = frame_i ? '0 : idx_q;
    cur_used = frame_i ? '0 : used_q;
    cur_done = frame_i ? 1'b0 : done_q;
    cur_ent  = frame_i ? shadow_q[0] : active_q[idx_q];
    dst_o    = cur_done ? '0 : cur_ent.dst;

    idx_n  = cur_idx;
    used_n = cur_used + 1'b1;
    done_n = cur_done;
    if (cur_used == cur_ent.cnt) begin
      used_n = '0;
      if (cur_ent.last || cur_idx == IDX_W'(MAX_ENT - 1)) done_n = 1'b1;
      else                                                idx_n  = cur_idx + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      used_q <= '0;
      done_q <= 1'b1;
    end else if (slot_i) begin
      idx_q  <= idx_n;
      used_q <= used_n;
      done_q <= done_n;
    end
  end

  assert_done_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !(slot_i && frame_i)) |=> done_q);

  assert_run_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> (used_q <= active_q[idx_q].cnt));
endmodule

// File: rtl/tsr_rx_steer.sv
module tsr_rx_steer
  import tsr_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  slot_i,
  input  logic [TSR_CODE_W-1:0] dst_i,
  input  logic [BYTE_W-1:0]     byte_i,
  output logic                  valid_o,
  output logic [TSR_CODE_W-1:0] ch_o,
  output logic [BYTE_W-1:0]     byte_o,
  output logic [NUM_CH-1:0]     we_o
);
  logic [NUM_CH-1:0] we_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign we_d[c] = slot_i && (dst_i == TSR_CODE_W'(c + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
      byte_o  <= '0;
      we_o    <= '0;
    end else begin
      valid_o <= slot_i;
      we_o    <= we_d;
      if (slot_i) begin
        ch_o   <= dst_i;
        byte_o <= byte_i;
      end
    end
  end

  assert_we_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));

  assert_we_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o != '0) |-> valid_o);

  assert_valid_follows_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(slot_i));
endmodule

// File: rtl/tsr_tx_select.sv
module tsr_tx_select
  import tsr_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     slot_i,
  input  logic [TSR_CODE_W-1:0]    dst_i,
  input  logic [NUM_CH-1:0]        avail_i,
  input  logic [NUM_CH*BYTE_W-1:0] data_i,
  output logic                     valid_o,
  output logic [TSR_CODE_W-1:0]    ch_o,
  output logic [BYTE_W-1:0]        byte_o,
  output logic [NUM_CH-1:0]        pop_o
);
  logic [BYTE_W-1:0] lane;
  logic [NUM_CH-1:0] pop_d;

  // idle fill is all ones
  always_comb begin
    lane  = '1;
    pop_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (dst_i == TSR_CODE_W'(c + 1) && avail_i[c]) begin
        lane     = data_i[c*BYTE_W +: BYTE_W];
        pop_d[c] = slot_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
      byte_o  <= '1;
      pop_o   <= '0;
    end else begin
      valid_o <= slot_i;
      pop_o   <= pop_d;
      if (slot_i) begin
        ch_o   <= dst_i;
        byte_o <= lane;
      end
    end
  end

  assert_pop_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o));

  assert_pop_had_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o != '0) |-> ((pop_o & ~$past(avail_i)) == '0));

  assert_unused_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ch_o == '0) |-> (byte_o == '1 && pop_o == '0));
endmodule

// File: rtl/tsr_slot_router.sv
module tsr_slot_router
  import tsr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 5,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned MAX_ENT = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic                     cfg_tx_i,
  input  logic [$clog2(MAX_ENT)-1:0] cfg_idx_i,
  input  logic [TSR_CNT_W-1:0]     cfg_cnt_i,
  input  logic [TSR_CODE_W-1:0]    cfg_dst_i,
  input  logic                     cfg_last_i,
  input  logic                     rx_slot_i,
  input  logic                     rx_frame_i,
  input  logic [BYTE_W-1:0]        rx_byte_i,
  output logic                     rx_valid_o,
  output logic [TSR_CODE_W-1:0]    rx_ch_o,
  output logic [BYTE_W-1:0]        rx_byte_o,
  output logic [NUM_CH-1:0]        rx_we_o,
  input  logic                     tx_slot_i,
  input  logic                     tx_frame_i,
  input  logic [NUM_CH-1:0]        tx_avail_i,
  input  logic [NUM_CH*BYTE_W-1:0] tx_data_i,
  output logic                     tx_valid_o,
  output logic [TSR_CODE_W-1:0]    tx_ch_o,
  output logic [BYTE_W-1:0]        tx_byte_o,
  output logic [NUM_CH-1:0]        tx_pop_o
);
  tsr_route_t            wr_ent;
  logic [TSR_CODE_W-1:0] rx_dst, tx_dst;

  // codes beyond the channel count collapse to unused
  always_comb begin
    wr_ent.cnt  = cfg_cnt_i;
    wr_ent.last = cfg_last_i;
    wr_ent.dst  = (cfg_dst_i > TSR_CODE_W'(NUM_CH)) ? '0 : cfg_dst_i;
  end

  tsr_route_walker #(.MAX_ENT(MAX_ENT)) i_rx_walker (
    .clk_i, .rst_ni,
    .wr_en_i (cfg_we_i && !cfg_tx_i),
    .wr_idx_i(cfg_idx_i),
    .wr_ent_i(wr_ent),
    .slot_i  (rx_slot_i),
    .frame_i (rx_frame_i),
    .dst_o   (rx_dst)
  );

  tsr_route_walker #(.MAX_ENT(MAX_ENT)) i_tx_walker (
    .clk_i, .rst_ni,
    .wr_en_i (cfg_we_i && cfg_tx_i),
    .wr_idx_i(cfg_idx_i),
    .wr_ent_i(wr_ent),
    .slot_i  (tx_slot_i),
    .frame_i (tx_frame_i),
    .dst_o   (tx_dst)
  );

  tsr_rx_steer #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) i_rx_steer (
    .clk_i, .rst_ni,
    .slot_i (rx_slot_i),
    .dst_i  (rx_dst),
    .byte_i (rx_byte_i),
    .valid_o(rx_valid_o),
    .ch_o   (rx_ch_o),
    .byte_o (rx_byte_o),
    .we_o   (rx_we_o)
  );

  tsr_tx_select #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) i_tx_select (
    .clk_i, .rst_ni,
    .slot_i (tx_slot_i),
    .dst_i  (tx_dst),
    .avail_i(tx_avail_i),
    .data_i (tx_data_i),
    .valid_o(tx_valid_o),
    .ch_o   (tx_ch_o),
    .byte_o (tx_byte_o),
    .pop_o  (tx_pop_o)
  );

  assert_rx_code_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_ch_o <= TSR_CODE_W'(NUM_CH)));

  assert_tx_code_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_ch_o <= TSR_CODE_W'(NUM_CH)));
endmodule

// File: tb/test_tsr_slot_router.sv
`timescale 1ns/1ps
module test_tsr_slot_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cfg_we = 0, cfg_tx = 0, cfg_last = 0;
  logic [5:0] cfg_idx = 0, cfg_cnt = 0;
  logic [2:0] cfg_dst = 0;
  logic       rx_slot = 0, rx_frame = 0, tx_slot = 0, tx_frame = 0;
  logic [7:0] rx_byte = 0;
  logic [4:0] tx_avail = 0;
  logic [39:0] tx_data = 0;
  logic       rx_valid_o, tx_valid_o;
  logic [2:0] rx_ch_o, tx_ch_o;
  logic [7:0] rx_byte_o, tx_byte_o;
  logic [4:0] rx_we_o, tx_pop_o;

  tsr_slot_router i_tsr_slot_router (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_tx_i(cfg_tx), .cfg_idx_i(cfg_idx), .cfg_cnt_i(cfg_cnt),
    .cfg_dst_i(cfg_dst), .cfg_last_i(cfg_last),
    .rx_slot_i(rx_slot), .rx_frame_i(rx_frame), .rx_byte_i(rx_byte),
    .rx_valid_o(rx_valid_o), .rx_ch_o(rx_ch_o), .rx_byte_o(rx_byte_o), .rx_we_o(rx_we_o),
    .tx_slot_i(tx_slot), .tx_frame_i(tx_frame), .tx_avail_i(tx_avail), .tx_data_i(tx_data),
    .tx_valid_o(tx_valid_o), .tx_ch_o(tx_ch_o), .tx_byte_o(tx_byte_o), .tx_pop_o(tx_pop_o)
  );

  int checks = 0, errors = 0;
  bit fin = 0;
  int sh_cnt[2][64], sh_dst[2][64], ac_cnt[2][64], ac_dst[2][64];
  bit sh_last[2][64], ac_last[2][64];
  bit started = 0;
  int slot_no = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_code(int d, int s);
    int pos = 0;
    if (!started) return 0;
    for (int e = 0; e < 64; e++) begin
      if (s < pos + ac_cnt[d][e]) return ac_dst[d][e];
      pos += ac_cnt[d][e];
      if (ac_last[d][e]) return 0;
    end
    return 0;
  endfunction

  task automatic write_entry(int d, int idx, int n, int dst, bit last);
    @(negedge clk);
    cfg_we = 1; cfg_tx = d[0]; cfg_idx = 6'(idx); cfg_cnt = 6'(n - 1);
    cfg_dst = 3'(dst); cfg_last = last;
    @(negedge clk);
    cfg_we = 0;
    sh_cnt[d][idx] = n; sh_dst[d][idx] = (dst > 5) ? 0 : dst; sh_last[d][idx] = last;
  endtask

  task automatic run_slot(bit frame, string rtag, string ttag);
    int rc, tc;
    logic [7:0] rb, eb;
    logic [4:0] av, ewe, epop;
    logic [39:0] td;
    @(negedge clk);
    rb = 8'($urandom); av = 5'($urandom); td = {8'($urandom), 32'($urandom)};
    rx_slot = 1; tx_slot = 1; rx_frame = frame; tx_frame = frame;
    rx_byte = rb; tx_avail = av; tx_data = td;
    if (frame) begin
      ac_cnt = sh_cnt; ac_dst = sh_dst; ac_last = sh_last;
      started = 1; slot_no = 0;
    end
    rc = exp_code(0, slot_no);
    tc = exp_code(1, slot_no);
    ewe = (rc != 0) ? 5'(1 << (rc - 1)) : 5'd0;
    if (tc != 0 && av[tc-1]) begin
      eb = td[(tc-1)*8 +: 8]; epop = 5'(1 << (tc - 1));
    end else begin
      eb = 8'hff; epop = 5'd0;
    end
    @(negedge clk);
    rx_slot = 0; tx_slot = 0; rx_frame = 0; tx_frame = 0;
    chk(rx_valid_o == 1'b1, "R4", "rx_valid", rx_valid_o, 1);
    chk(rx_ch_o == 3'(rc), rtag, "rx_ch", rx_ch_o, rc);
    chk(rx_we_o == ewe, "R4", "rx_we", rx_we_o, ewe);
    chk(rx_byte_o == rb, "R4", "rx_byte", rx_byte_o, rb);
    chk(tx_valid_o == 1'b1, "R5", "tx_valid", tx_valid_o, 1);
    chk(tx_ch_o == 3'(tc), ttag, "tx_ch", tx_ch_o, tc);
    chk(tx_byte_o == eb, (epop != 0) ? "R5" : "R6", "tx_byte", tx_byte_o, eb);
    chk(tx_pop_o == epop, (epop != 0) ? "R5" : "R6", "tx_pop", tx_pop_o, epop);
    slot_no++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL R1 watchdog act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int d = 0; d < 2; d++)
      for (int e = 0; e < 64; e++) begin
        sh_cnt[d][e] = 1; sh_dst[d][e] = 0; sh_last[d][e] = 0;
      end
    repeat (3) @(negedge clk);
    chk(rx_valid_o == 0 && rx_we_o == 0, "R10", "rx reset", {rx_valid_o, rx_we_o}, 0);
    chk(tx_valid_o == 0 && tx_pop_o == 0, "R10", "tx reset", {tx_valid_o, tx_pop_o}, 0);
    rst_n = 1;

    // before any frame start
    repeat (3) run_slot(0, "R10", "R10");

    // directed runs, different tables per direction
    write_entry(0, 0, 2, 0, 0);
    write_entry(0, 1, 3, 1, 0);
    write_entry(0, 2, 4, 0, 0);
    write_entry(0, 3, 2, 2, 1);
    write_entry(1, 0, 1, 3, 0);
    write_entry(1, 1, 2, 5, 0);
    write_entry(1, 2, 1, 4, 1);
    run_slot(1, "R1", "R8");
    for (int s = 1; s < 11; s++) run_slot(0, "R1", "R8");
    for (int s = 11; s < 14; s++) run_slot(0, "R3", "R3");
    @(negedge clk);
    chk(rx_valid_o == 0 && tx_valid_o == 0, "R4", "idle valid", {rx_valid_o, tx_valid_o}, 0);

    // longest run and full 64-entry table
    write_entry(0, 0, 64, 4, 1);
    for (int e = 0; e < 64; e++) write_entry(1, e, 1, (e % 5) + 1, 0);
    run_slot(1, "R1", "R1");
    for (int s = 1; s < 64; s++) run_slot(0, "R1", "R1");
    run_slot(0, "R3", "R3");
    run_slot(0, "R3", "R3");

    // restart mid-table
    write_entry(0, 0, 2, 1, 0);
    write_entry(0, 1, 3, 3, 1);
    run_slot(1, "R2", "R2");
    run_slot(0, "R2", "R2");
    run_slot(0, "R2", "R2");
    run_slot(1, "R2", "R2");
    run_slot(0, "R2", "R2");

    // update during a frame
    write_entry(0, 0, 2, 1, 1);
    run_slot(1, "R7", "R7");
    write_entry(0, 0, 2, 2, 1);
    run_slot(0, "R7", "R7");
    run_slot(0, "R7", "R7");
    run_slot(1, "R7", "R7");
    run_slot(0, "R7", "R7");

    // out-of-range codes
    write_entry(0, 0, 3, 6, 1);
    write_entry(1, 0, 2, 7, 0);
    write_entry(1, 1, 1, 2, 1);
    run_slot(1, "R9", "R9");
    for (int s = 1; s < 4; s++) run_slot(0, "R9", "R9");

    // random tables and frame lengths
    for (int it = 0; it < 25; it++) begin
      for (int d = 0; d < 2; d++) begin
        int ne;
        ne = 1 + int'($urandom % 8);
        for (int e = 0; e < ne; e++)
          write_entry(d, e, 1 + int'($urandom % 6), int'($urandom % 8), e == ne - 1);
      end
      begin
        int ns;
        ns = 1 + int'($urandom % 40);
        run_slot(1, "R1", "R1");
        for (int s = 1; s < ns; s++) run_slot(0, "R1", "R1");
      end
    end

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule